// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is the register side of a 32-pin general-purpose I/O port. Software on a simple 32-bit register bus sets each pin's direction and output level, reads pin levels, programs the trigger configuration for each pin, and masks, inspects and acknowledges pending pin events. Pin levels are sampled into a pad status register on every clock. The block drives the pin output levels and output enables. It also exports the trigger configuration and the any-edge selection to a separate per-pin detection block.

The detection block returns one-cycle event set requests, `irq_set`. The block latches these into a sticky status register. The masked status produces either one interrupt request, or two requests (pins 15:0 and pins 31:16) when `SPLIT_IRQ` is set. The any-edge selection register is present only when `EDGE_EN` is set.

The bus has no byte enables, so every access is a full word. A read returns its data combinationally in the cycle the access is presented. A write takes effect at the next rising clock edge.

Top module: `gpio_regs`

## Requirements
- R1: After reset every register reads 0, `pin_out` and `pin_oe` are 0, `trig_cfg` and `any_edge` are 0, and both `irq` bits are 0.
- R2: `pin_oe` equals the direction word at byte offset 0x04, where bit 1 means output. `pin_out` equals the data word at offset 0x00. Both change one clock edge after the write and at no other time.
- R3: A read of offset 0x00 returns the data-word bits where the direction bit is 1, and the sampled pin levels where it is 0. The pins are sampled into the pad register at every clock edge.
- R4: A read of offset 0x08 returns the sampled pin levels with output-pin bits forced to 0. A write to offset 0x08 has no effect.
- R5: Offset 0x0C holds the trigger configuration for pins 15:0 and offset 0x10 holds it for pins 31:16. Both read back as written and drive `trig_cfg[31:0]` and `trig_cfg[63:32]`.
- R6: Each `irq_set` bit sets the matching bit of the status register at offset 0x18. That bit stays set until a write to 0x18 has a 1 in its position. A write clears exactly the bits written as 1.
- R7: When a clear and a set request hit the same status bit in the same cycle, the bit stays set.
- R8: With `SPLIT_IRQ`=0, `irq[0]` is 1 exactly when status AND mask (offset 0x14) is nonzero, and `irq[1]` is 0.
- R9: With `SPLIT_IRQ`=1, `irq[0]` reflects bits 15:0 of status AND mask and `irq[1]` reflects bits 31:16.
- R10: With `EDGE_EN`=1, offset 0x1C reads back as written and drives `any_edge`. With `EDGE_EN`=0, it reads 0, writes are ignored and `any_edge` stays 0.
- R11: An access whose byte address is not a multiple of 4, or is 0x20 or above, reads 0 and changes nothing. `bus_err` is 1 during exactly the cycle of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Unmapped access in this cycle |
| pin_in | input | 32 | Pin levels |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables |
| trig_cfg | output | 64 | Two configuration bits per pin, to the detector |
| any_edge | output | 32 | Any-edge selection, to the detector |
| irq_set | input | 32 | Event set requests from the detector |
| irq | output | 2 | Interrupt requests |

## Verification
Read data and `bus_err` are combinational, so the bench samples them 1 ns after it presents an access at the falling edge. Writes and `irq_set` pulses are sampled at the next rising edge, so their effect on `pin_out`, `pin_oe`, `trig_cfg`, status and `irq` is checked at the falling edge after that. A change on `pin_in` goes through one sampling register, so reads of offsets 0x00 and 0x08 are checked two falling edges after the pins change. A second instance with the split interrupt enabled and the any-edge register removed shares the stimulus, which covers both parameter variants.

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int ADDR_W    = 6,
  parameter bit EDGE_EN   = 1'b1,
  parameter bit SPLIT_IRQ = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe,
  output logic [63:0]       trig_cfg,
  output logic [31:0]       any_edge,
  input  logic [31:0]       irq_set,
  output logic [1:0]        irq
);

  localparam int NREG = 8;

  logic [31:0] dat_q, dir_q, pad_q, cfg_lo_q, cfg_hi_q, msk_q, sts_q, edg_q;
  logic [31:0] rd_mux, clr, pend;
  logic [NREG-1:0] wsel;
  logic hit, wen;
  logic [2:0] idx;

  assign hit = (bus_addr[1:0] == 2'b00) && (bus_addr < ADDR_W'(NREG * 4));
  assign idx = bus_addr[4:2];
  assign wen = bus_sel && bus_wr && hit;
  assign bus_err = bus_sel && !hit;

  always_comb begin
    wsel = '0;
    wsel[idx] = wen;
  end

  assign clr = wsel[6] ? bus_wdata : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q    <= '0;
      dir_q    <= '0;
      pad_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      msk_q    <= '0;
      sts_q    <= '0;
    end else begin
      pad_q <= pin_in;
      sts_q <= (sts_q & ~clr) | irq_set;
      if (wsel[0]) dat_q    <= bus_wdata;
      if (wsel[1]) dir_q    <= bus_wdata;
      if (wsel[3]) cfg_lo_q <= bus_wdata;
      if (wsel[4]) cfg_hi_q <= bus_wdata;
      if (wsel[5]) msk_q    <= bus_wdata;
    end
  end

  generate
    if (EDGE_EN) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       edg_q <= '0;
        else if (wsel[7]) edg_q <= bus_wdata;
      end
    end else begin : g_no_edge
      assign edg_q = '0;
    end
  endgenerate

  always_comb begin
    case (idx)
      3'd0:    rd_mux = (dat_q & dir_q) | (pad_q & ~dir_q);
      3'd1:    rd_mux = dir_q;
      3'd2:    rd_mux = pad_q & ~dir_q;
      3'd3:    rd_mux = cfg_lo_q;
      3'd4:    rd_mux = cfg_hi_q;
      3'd5:    rd_mux = msk_q;
      3'd6:    rd_mux = sts_q;
      default: rd_mux = edg_q;
    endcase
  end

  assign bus_rdata = (bus_sel && !bus_wr && hit) ? rd_mux : 32'h0;

  assign pin_out  = dat_q;
  assign pin_oe   = dir_q;
  assign trig_cfg = {cfg_hi_q, cfg_lo_q};
  assign any_edge = edg_q;

  assign pend = sts_q & msk_q;
  generate
    if (SPLIT_IRQ) begin : g_split
      assign irq = {|pend[31:16], |pend[15:0]};
    end else begin : g_single
      assign irq = {1'b0, |pend};
    end
  endgenerate

  AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_set) |=> ((sts_q & $past(irq_set)) == $past(irq_set))); // R7

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(irq_set)) == 32'h0)); // R6

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == ADDR_W'(4)) |=> $stable(pin_oe)); // R2

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == ADDR_W'(0)) |=> $stable(pin_out)); // R2

  AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> ($stable(pin_out) && $stable(pin_oe) && $stable(trig_cfg)
                 && $stable(any_edge) && $stable(msk_q))); // R11

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == 32'h0)); // R11

endmodule

// File: tb/test_gpio_regs.sv
module test_gpio_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0, irq_set = '0;
  logic [31:0] rdata, pin_out, pin_oe, any_edge;
  logic [31:0] rdata_b, pin_out_b, pin_oe_b, any_edge_b;
  logic [63:0] trig_cfg, trig_cfg_b;
  logic err, err_b;
  logic [1:0] irq, irq_b;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_regs #(.ADDR_W(AW), .EDGE_EN(1'b1), .SPLIT_IRQ(1'b0)) i_gpio_regs (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata(rdata), .bus_err(err), .pin_in, .pin_out, .pin_oe,
    .trig_cfg, .any_edge, .irq_set, .irq);

  gpio_regs #(.ADDR_W(AW), .EDGE_EN(1'b0), .SPLIT_IRQ(1'b1)) i_gpio_regs_alt (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata(rdata_b), .bus_err(err_b), .pin_in, .pin_out(pin_out_b),
    .pin_oe(pin_oe_b), .trig_cfg(trig_cfg_b), .any_edge(any_edge_b),
    .irq_set, .irq(irq_b));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(req, rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic pulse_set(input logic [31:0] v);
    @(negedge clk);
    irq_set = v;
    @(negedge clk);
    irq_set = '0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) rd("R1", AW'(i * 4), 32'h0);
    chk("R1", pin_oe, 0); chk("R1", pin_out, 0);
    chk("R1", trig_cfg, 0); chk("R1", any_edge, 0);
    chk("R1", irq, 0); chk("R1", irq_b, 0);
  endtask

  task automatic t_pins;
    wr(6'h04, 32'h0000FF00);
    wr(6'h00, 32'h12345678);
    chk("R2", pin_oe, 32'h0000FF00);
    chk("R2", pin_out, 32'h12345678);
    pin_in = 32'hA5A5A5A5;
    @(negedge clk); @(negedge clk);
    rd("R3", 6'h00, 32'hA5A556A5);
    rd("R4", 6'h08, 32'hA5A500A5);
    wr(6'h08, 32'hFFFFFFFF);
    rd("R4", 6'h08, 32'hA5A500A5);
    chk("R2", pin_oe, 32'h0000FF00);
  endtask

  task automatic t_cfg;
    wr(6'h0C, 32'hDEADBEEF);
    wr(6'h10, 32'h01234567);
    rd("R5", 6'h0C, 32'hDEADBEEF);
    rd("R5", 6'h10, 32'h01234567);
    chk("R5", trig_cfg, 64'h01234567DEADBEEF);
  endtask

  task automatic t_status;
    pulse_set(32'h00F0000F);
    rd("R6", 6'h18, 32'h00F0000F);
    wr(6'h18, 32'h0000000C);
    rd("R6", 6'h18, 32'h00F00003);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h18; bus_wdata = 32'hFFFFFFFF;
    irq_set = 32'h00000001;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; irq_set = '0;
    rd("R7", 6'h18, 32'h00000001);
    wr(6'h18, 32'hFFFFFFFF);
    rd("R6", 6'h18, 32'h0);
  endtask

  task automatic t_irq;
    wr(6'h14, 32'h00010008);
    chk("R8", irq, 2'b00);
    pulse_set(32'h00010000);
    chk("R8", irq, 2'b01);
    chk("R9", irq_b, 2'b10);
    pulse_set(32'h00000008);
    chk("R9", irq_b, 2'b11);
    wr(6'h18, 32'h00010000);
    chk("R9", irq_b, 2'b01);
    chk("R8", irq, 2'b01);
    wr(6'h18, 32'h00000008);
    chk("R8", irq, 2'b00);
    chk("R9", irq_b, 2'b00);
    pulse_set(32'h00020000);
    chk("R8", irq, 2'b00);
  endtask

  task automatic t_edge;
    wr(6'h1C, 32'h0F0F0F0F);
    chk("R10", any_edge, 32'h0F0F0F0F);
    chk("R10", any_edge_b, 32'h0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'h1C;
    #1;
    chk("R10", rdata, 32'h0F0F0F0F);
    chk("R10", rdata_b, 32'h0);
    bus_sel = 1'b0;
  endtask

  task automatic t_unmapped;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h24; bus_wdata = 32'hFFFFFFFF;
    #1 chk("R11", err, 1'b1);
    @(negedge clk);
    bus_addr = 6'h06;
    #1 chk("R11", err, 1'b1);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    #1 chk("R11", err, 1'b0);
    chk("R11", pin_oe, 32'h0000FF00);
    chk("R11", pin_out, 32'h12345678);
    chk("R11", trig_cfg, 64'h01234567DEADBEEF);
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = 6'h30;
    #1 chk("R11", rdata, 32'h0);
    chk("R11", err, 1'b1);
    bus_sel = 1'b0;
    rd("R11", 6'h04, 32'h0000FF00);
    chk("R11", err, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_pins;
    t_cfg;
    t_status;
    t_irq;
    t_edge;
    t_unmapped;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule